// File: doc/BRIEF.md
# Instrument Bus Master Sequencer

This block is the host-side master of a simple two-bus instrument link that reaches up to sixteen remote instruments. One bus carries a 4-bit command code together with a data-valid strobe and a high/low byte select. The other is an 8-bit address/data bus that either end may drive. The host presents one request: an operation, a target instrument address, a register address byte, a data byte and a byte select. The sequencer expands it into the sequence of strobed command steps the remote instruments expect. A step is the command code held for a setup interval, then the strobe held high for a pulse interval.

Each transaction except the global reset first selects the target instrument. Register and memory accesses then load the remote's register address latch. The access itself comes last. On read steps the master lets go of the data bus before the strobe rises and captures the remote's byte when the strobe falls. The remote's active-low service-request line passes through a synchronizer and is gated by an enable bit into a host interrupt.

Top module: `ibus_master`

## Requirements
- R1: After reset `busy`, `cmd_rdy`, `cmd_hl`, `bus_oe`, `xcvr_en`, `done`, `rd_valid` and `irq` are 0 and `cmd_code` is 0.
- R2: The operation `req_op` expands into these command code sequences. 0 (reset all): 0. 1 (write): 15, 5, 1. 2 (read register): 15, 5, 2. 3 (read memory): 15, 5, 3. 4 (read status): 15, 4. 5 (select): 15. 6 (clear service request): 15, 6. 7 (start): 15, 7.
- R3: A request is accepted on a clock edge with `req_valid` high and `busy` low. Each step then holds its code for SETUP_CYC cycles with `cmd_rdy` low, followed by PULSE_CYC cycles with `cmd_rdy` high. The next step's code appears in the cycle `cmd_rdy` falls, so an N-step operation keeps `busy` high for N*(SETUP_CYC+PULSE_CYC) cycles.
- R4: While the master drives the data bus, code 15 steps carry `{4'h0, req_dev}`, code 5 steps carry `req_addr` unchanged (bit 7 included), code 1 steps carry `req_data`, and all other steps carry 8'h00.
- R5: On read steps (codes 2, 3 and 4), `bus_oe` drops in the last setup cycle, one cycle before `cmd_rdy` rises, and stays low to the end of the step. It is high in every other step and low when idle. `xcvr_en` equals `busy`.
- R6: On a read operation, `rd_data` takes `bus_din` as sampled on the edge at which `cmd_rdy` falls on the read step. `rd_valid` pulses for one cycle, in the first cycle `busy` is low.
- R7: `cmd_hl` equals the accepted `req_hi` throughout a transaction and is 0 when idle.
- R8: Requests presented while `busy` is high are ignored, and the running sequence continues unchanged.
- R9: `done` pulses for exactly one cycle, in the first cycle after `busy` falls, for every operation.
- R10: `irq` is high when `irq_en` is high and `srq_n` was low SYNC_STAGES clock edges earlier (2 by default). It is 0 whenever `irq_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 3 | Operation code (see R2) |
| req_dev | input | 4 | Target instrument address |
| req_addr | input | 8 | Register address latch byte |
| req_data | input | 8 | Write data byte |
| req_hi | input | 1 | High/low byte select for the transaction |
| irq_en | input | 1 | Service-request interrupt enable |
| srq_n | input | 1 | Active-low service request from the bus |
| bus_din | input | 8 | Data bus as seen by the master |
| cmd_code | output | 4 | Command code lines |
| cmd_rdy | output | 1 | Data-valid strobe qualifying the code |
| cmd_hl | output | 1 | High/low byte select line |
| bus_dout | output | 8 | Data the master drives onto the bus |
| bus_oe | output | 1 | Master drives the data bus |
| xcvr_en | output | 1 | Data transceiver enable |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle read-data-valid pulse |
| rd_data | output | 8 | Captured read byte |
| irq | output | 1 | Host interrupt |

## Verification
When a request is accepted at edge t, step k's code is due in cycles t+k*(S+P)+1 through t+(k+1)*(S+P). The strobe is due in the last P of those cycles. On read steps the bus release is due from cycle t+k*(S+P)+S onward. `done`, `rd_valid` and `rd_data` are due in cycle t+N*(S+P)+1. The bench drives requests on the falling edge and samples every output on each following falling edge. It derives the expected value of each cycle from the cycle offset. It also changes `bus_din` as soon as the strobe drops, so a capture taken on the wrong edge returns the wrong byte. The interrupt is checked one and two edges after the service request changes.

// File: rtl/ibus_pkg.sv
package ibus_pkg;

  typedef enum logic [2:0] {
    OP_RESET_ALL = 3'd0,
    OP_WRITE     = 3'd1,
    OP_READ_REG  = 3'd2,
    OP_READ_MEM  = 3'd3,
    OP_READ_STAT = 3'd4,
    OP_SELECT    = 3'd5,
    OP_CLR_SRQ   = 3'd6,
    OP_START     = 3'd7
  } ibus_op_e;

  localparam logic [3:0] CODE_RESET  = 4'd0;
  localparam logic [3:0] CODE_WRITE  = 4'd1;
  localparam logic [3:0] CODE_RDREG  = 4'd2;
  localparam logic [3:0] CODE_RDMEM  = 4'd3;
  localparam logic [3:0] CODE_RDSTAT = 4'd4;
  localparam logic [3:0] CODE_LATCH  = 4'd5;
  localparam logic [3:0] CODE_CLRSRQ = 4'd6;
  localparam logic [3:0] CODE_START  = 4'd7;
  localparam logic [3:0] CODE_ENABLE = 4'd15;

  // number of command steps an operation expands into
  function automatic logic [1:0] op_steps(input ibus_op_e op);
    case (op)
      OP_RESET_ALL, OP_SELECT:               op_steps = 2'd1;
      OP_READ_STAT, OP_CLR_SRQ, OP_START:    op_steps = 2'd2;
      default:                               op_steps = 2'd3;
    endcase
  endfunction

  // command code of step idx of an operation
  function automatic logic [3:0] op_code(input ibus_op_e op, input logic [1:0] idx);
    op_code = CODE_ENABLE;
    if (op == OP_RESET_ALL) begin
      op_code = CODE_RESET;
    end else if (idx == 2'd1) begin
      case (op)
        OP_READ_STAT: op_code = CODE_RDSTAT;
        OP_CLR_SRQ:   op_code = CODE_CLRSRQ;
        OP_START:     op_code = CODE_START;
        default:      op_code = CODE_LATCH;
      endcase
    end else if (idx == 2'd2) begin
      case (op)
        OP_READ_REG: op_code = CODE_RDREG;
        OP_READ_MEM: op_code = CODE_RDMEM;
        default:     op_code = CODE_WRITE;
      endcase
    end
  endfunction

  function automatic logic code_is_read(input logic [3:0] code);
    code_is_read = (code == CODE_RDREG) || (code == CODE_RDMEM) || (code == CODE_RDSTAT);
  endfunction

  // byte placed on the data bus during a step
  function automatic logic [7:0] code_byte(input logic [3:0] code, input logic [3:0] dev,
                                           input logic [7:0] addr, input logic [7:0] data);
    case (code)
      CODE_ENABLE: code_byte = {4'h0, dev};
      CODE_LATCH:  code_byte = addr;
      CODE_WRITE:  code_byte = data;
      default:     code_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ibus_step_timer.sv
module ibus_step_timer #(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic strobe,
  output logic last_setup,
  output logic step_end
);
  localparam int MAXC = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);

  logic          phase_q;
  logic [CW-1:0] cnt_q;

  assign strobe     = active && phase_q;
  assign last_setup = active && !phase_q && (cnt_q == SETUP_LAST);
  assign step_end   = active && phase_q && (cnt_q == PULSE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!active) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (last_setup) begin
      phase_q <= 1'b1;
      cnt_q   <= '0;
    end else if (step_end) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  no_idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !strobe);
  // R3
  strobe_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(last_setup));
endmodule

// File: rtl/ibus_seq.sv
module ibus_seq
  import ibus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  input  logic [3:0] req_dev,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_data,
  input  logic       req_hi,
  input  logic       step_end,
  input  logic [7:0] bus_din,
  output logic       busy,
  output ibus_op_e   op_q,
  output logic [1:0] idx_q,
  output logic [3:0] dev_q,
  output logic [7:0] addr_q,
  output logic [7:0] data_q,
  output logic       hi_q,
  output logic       done,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  logic       accept;
  logic       last_step;
  logic       finish;
  logic       read_now;

  assign accept    = req_valid && !busy;
  assign last_step = (idx_q == op_steps(op_q) - 2'd1);
  assign finish    = step_end && last_step;
  assign read_now  = finish && code_is_read(op_code(op_q, idx_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      op_q     <= OP_RESET_ALL;
      idx_q    <= 2'd0;
      dev_q    <= 4'h0;
      addr_q   <= 8'h00;
      data_q   <= 8'h00;
      hi_q     <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      done     <= finish;
      rd_valid <= read_now;
      if (read_now) rd_data <= bus_din;
      if (accept) begin
        busy   <= 1'b1;
        op_q   <= ibus_op_e'(req_op);
        idx_q  <= 2'd0;
        dev_q  <= req_dev;
        addr_q <= req_addr;
        data_q <= req_data;
        hi_q   <= req_hi;
      end else if (finish) begin
        busy  <= 1'b0;
        idx_q <= 2'd0;
      end else if (step_end) begin
        idx_q <= idx_q + 2'd1;
      end
    end
  end

  // R8
  req_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> (op_q == $past(op_q)) && (dev_q == $past(dev_q)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !$past(done));
  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx_q < op_steps(op_q));
endmodule

// File: rtl/ibus_srq_gate.sv
module ibus_srq_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srq_n,
  input  logic irq_en,
  output logic irq
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ~srq_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ~srq_n};
      end
    end
  endgenerate

  assign irq = irq_en && sync_q[SYNC_STAGES-1];

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $stable(irq_en)) |-> $past(!srq_n));
endmodule

// File: rtl/ibus_master.sv
module ibus_master
  import ibus_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  input  logic [3:0] req_dev,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_data,
  input  logic       req_hi,
  input  logic       irq_en,
  input  logic       srq_n,
  input  logic [7:0] bus_din,
  output logic [3:0] cmd_code,
  output logic       cmd_rdy,
  output logic       cmd_hl,
  output logic [7:0] bus_dout,
  output logic       bus_oe,
  output logic       xcvr_en,
  output logic       busy,
  output logic       done,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       irq
);
  ibus_op_e   op_q;
  logic [1:0] idx_q;
  logic [3:0] dev_q;
  logic [7:0] addr_q;
  logic [7:0] data_q;
  logic       hi_q;
  logic       strobe;
  logic       last_setup;
  logic       step_end;
  logic [3:0] step_code;
  logic       step_reads;

  ibus_step_timer #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(busy),
    .strobe(strobe), .last_setup(last_setup), .step_end(step_end)
  );

  ibus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_dev(req_dev), .req_addr(req_addr), .req_data(req_data), .req_hi(req_hi),
    .step_end(step_end), .bus_din(bus_din), .busy(busy), .op_q(op_q), .idx_q(idx_q),
    .dev_q(dev_q), .addr_q(addr_q), .data_q(data_q), .hi_q(hi_q), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  ibus_srq_gate #(.SYNC_STAGES(SYNC_STAGES)) u_srq (
    .clk(clk), .rst_n(rst_n), .srq_n(srq_n), .irq_en(irq_en), .irq(irq)
  );

  assign step_code  = op_code(op_q, idx_q);
  assign step_reads = code_is_read(step_code);
  assign cmd_code   = busy ? step_code : CODE_RESET;
  assign cmd_rdy    = strobe;
  assign cmd_hl     = busy && hi_q;
  assign bus_oe     = busy && !(step_reads && (strobe || last_setup));
  assign bus_dout   = bus_oe ? code_byte(step_code, dev_q, addr_q, data_q) : 8'h00;
  assign xcvr_en    = busy;

  // R3
  code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdy && $past(cmd_rdy)) |-> (cmd_code == $past(cmd_code)));
  // R3
  code_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_rdy) |-> $stable(cmd_code));
  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdy && code_is_read(cmd_code)) |-> !bus_oe);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_oe && !cmd_rdy && !cmd_hl && cmd_code == CODE_RESET));
  // R6
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_rdy) && (rd_data == $past(bus_din)));
endmodule

// File: tb/ibus_master_test.sv
module ibus_master_test;
  localparam int S = 2;
  localparam int P = 2;
  localparam int L = S + P;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [3:0] req_dev = 4'h0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_data = 8'h00;
  logic       req_hi = 1'b0;
  logic       irq_en = 1'b0;
  logic       srq_n = 1'b1;
  logic [7:0] bus_din = 8'h00;
  logic [3:0] cmd_code;
  logic       cmd_rdy, cmd_hl, bus_oe, xcvr_en, busy, done, rd_valid, irq;
  logic [7:0] bus_dout, rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ibus_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_dev(req_dev),
    .req_addr(req_addr), .req_data(req_data), .req_hi(req_hi), .irq_en(irq_en),
    .srq_n(srq_n), .bus_din(bus_din), .cmd_code(cmd_code), .cmd_rdy(cmd_rdy),
    .cmd_hl(cmd_hl), .bus_dout(bus_dout), .bus_oe(bus_oe), .xcvr_en(xcvr_en),
    .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected sequences packed low step first, one nibble per step
  function automatic logic [11:0] seq_of(input int op);
    case (op)
      0: return 12'h000;
      1: return 12'h15F;
      2: return 12'h25F;
      3: return 12'h35F;
      4: return 12'h04F;
      5: return 12'h00F;
      6: return 12'h06F;
      default: return 12'h07F;
    endcase
  endfunction

  function automatic int len_of(input int op);
    if (op == 0 || op == 5) return 1;
    if (op >= 1 && op <= 3) return 3;
    return 2;
  endfunction

  task automatic run_op(input int op, input logic [3:0] dev, input logic [7:0] addr,
                        input logic [7:0] data, input logic hi, input logic [7:0] rv,
                        input bit intrude);
    int n = len_of(op);
    logic [11:0] sq = seq_of(op);
    bit rd_op = (op >= 2 && op <= 4);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_dev = dev; req_addr = addr;
    req_data = data; req_hi = hi;
    for (int c = 1; c <= n * L; c++) begin
      int k = (c - 1) / L;
      int p = (c - 1) % L;
      logic [3:0] ec = sq[4*k +: 4];
      bit erd = (ec == 4'd2 || ec == 4'd3 || ec == 4'd4);
      bit erdy = (p >= S);
      bit eoe = !(erd && p >= S - 1);
      logic [7:0] eb = (ec == 4'd15) ? {4'h0, dev} : (ec == 4'd5) ? addr :
                       (ec == 4'd1) ? data : 8'h00;
      @(negedge clk);
      if (c == 1) begin
        req_valid = 1'b0;
      end
      if (intrude && c == 3) begin
        req_valid = 1'b1; req_op = 3'd0; req_dev = ~dev; req_addr = ~addr;
      end
      if (intrude && c == 4) req_valid = 1'b0;
      chk(busy === 1'b1 && xcvr_en === 1'b1, "R8 busy/xcvr", {busy, xcvr_en}, 3);
      chk(cmd_code === ec, "R2 code", cmd_code, ec);
      chk(cmd_rdy === erdy, "R3 strobe", cmd_rdy, erdy);
      chk(bus_oe === eoe, "R5 bus release", bus_oe, eoe);
      if (eoe) chk(bus_dout === eb, "R4 bus byte", bus_dout, eb);
      chk(cmd_hl === hi, "R7 hl", cmd_hl, hi);
      chk(done === 1'b0 && rd_valid === 1'b0, "R9 early done", {done, rd_valid}, 0);
      bus_din = (erd && erdy) ? rv : ~rv;
    end
    @(negedge clk);
    chk(busy === 1'b0 && xcvr_en === 1'b0, "R3 busy end", {busy, xcvr_en}, 0);
    chk(done === 1'b1, "R9 done pulse", done, 1);
    chk(rd_valid === rd_op, "R6 rd_valid", rd_valid, rd_op);
    if (rd_op) chk(rd_data === rv, "R6 rd_data", rd_data, rv);
    chk(bus_oe === 1'b0 && cmd_hl === 1'b0, "R5 idle bus", {bus_oe, cmd_hl}, 0);
    @(negedge clk);
    chk(done === 1'b0 && rd_valid === 1'b0, "R9 single pulse", {done, rd_valid}, 0);
    chk(busy === 1'b0, "R8 intrusion not started", busy, 0);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({busy, cmd_rdy, cmd_hl, bus_oe, xcvr_en, done, rd_valid, irq} === 8'h00,
        "R1 reset outputs", {busy, cmd_rdy, cmd_hl, bus_oe, xcvr_en, done, rd_valid, irq}, 0);
    chk(cmd_code === 4'd0, "R1 reset code", cmd_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 8; op++) begin
      for (int v = 0; v < 2; v++) begin
        logic [3:0] dv = 4'(op * 2 + v * 9);
        logic [7:0] ad = 8'(op * 17 + v * 128);
        logic [7:0] dt = 8'(8'hA5 ^ (op * 29 + v));
        logic [7:0] rv = 8'(8'h3C + op * 41 + v * 7);
        run_op(op, dv, ad, dt, v[0], rv, 1'b0);
      end
    end
    // R8 requests while busy are ignored
    run_op(1, 4'hC, 8'h07, 8'h5A, 1'b1, 8'h11, 1'b1);
    run_op(2, 4'h3, 8'h81, 8'h00, 1'b0, 8'hE7, 1'b1);
    // R10 interrupt gating
    irq_en = 1'b0; srq_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(irq === 1'b0, "R10 masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R10 enabled", irq, 1);
    srq_n = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R10 sync stage 1", irq, 1);
    @(negedge clk);
    chk(irq === 1'b0, "R10 released", irq, 0);
    srq_n = 1'b0;
    @(negedge clk);
    chk(irq === 1'b0, "R10 one edge", irq, 0);
    @(negedge clk);
    chk(irq === 1'b1, "R10 two edges", irq, 1);
    irq_en = 1'b0;
    #1;
    chk(irq === 1'b0, "R10 mask drop", irq, 0);
    srq_n = 1'b1;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule